// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry input without any clock. The operand word is split into four slices of four bits. Each slice derives its internal carries directly from per-bit carry-making and carry-passing terms instead of handing a carry from one bit to the next. A second lookahead stage then takes the four slice summaries and the incoming carry and produces the carry entering each slice. Slice widths and slice counts are parameters, so the same structure can be built at other sizes.

Besides the sum and the carry out, the block presents a block-wide carry-make flag and a block-wide carry-pass flag. A wider adder can feed these into another lookahead stage, treating this block as a single slice. The outputs depend only on the present inputs.

Top module: `cla_hier_adder`

## Requirements
- R1: For every input combination, `{cout_o, sum_o}` equals the 17-bit value `a_i + b_i + cin_i`.
- R2: `prop_o` is 1 exactly when every bit position has at least one of `a_i[k]` or `b_i[k]` set. The per-bit pass term is the OR of the two operand bits.
- R3: `gen_o` is 1 exactly when `a_i + b_i` with no carry input reaches or exceeds 2^16. The per-bit make term is the AND of the two operand bits.
- R4: `cout_o` equals `gen_o OR (prop_o AND cin_i)`.
- R5: A carry made in a lower slice reaches the correct sum bits of every higher slice across the boundaries at bits 4, 8 and 12.
- R6: When one operand is all ones, the other is zero and `cin_i` is 1, the carry passes through all 16 positions. The result is `sum_o` = 0, `cout_o` = 1, `prop_o` = 1 and `gen_o` = 0.
- R7: The outputs depend only on the present inputs. Applying the same inputs after a different earlier input pattern gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| cout_o | output | 1 | Carry out of bit 15 |
| gen_o | output | 1 | Block carry-make flag, for cascading |
| prop_o | output | 1 | Block carry-pass flag, for cascading |

## Verification
Several operand patterns are applied, and each one tells apart a different kind of carry fault:
- Zero operands show the quiet state of the block.
- Single carries launched just below each slice boundary show whether the second stage delivers the slice carries. These separate faults in that stage from faults inside a slice.
- The all-ones-plus-carry pattern drives the longest pass chain. It also separates the block pass flag from the make flag.
- Operands that make a carry only at the top bit, or only at the bottom bit, check that the make flag is distinct from the carry input.
- A stream of random operands and a sweep over all values of the low slice with varied upper bits compare every output against a plain integer sum.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DEF_GROUP_W  = 4;
  localparam int unsigned DEF_N_GROUPS = 4;
endpackage

// File: rtl/cla_pg.sv
module cla_pg #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign g_o[k] = a_i[k] & b_i[k];
    assign p_o[k] = a_i[k] | b_i[k];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      p_make_implies_pass_r3: assert ((g_o & ~p_o) == '0)
        else $error("make without pass");
    end
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  input  logic         cin_i,
  output logic [W-1:0] cry_o,
  output logic         gen_o,
  output logic         prop_o
);
  // Flat expansion: carry into position k is formed directly from inputs.
  always_comb begin
    for (int k = 0; k < W; k++) begin
      logic all_p;
      logic term;
      all_p = 1'b1;
      for (int m = 0; m < k; m++) all_p = all_p & prop_i[m];
      term = all_p & cin_i;
      for (int j = 0; j < k; j++) begin
        logic t;
        t = gen_i[j];
        for (int m = j + 1; m < k; m++) t = t & prop_i[m];
        term = term | t;
      end
      cry_o[k] = term;
    end
  end

  // Span summary built by merging adjacent spans from low to high.
  always_comb begin
    logic gacc;
    logic pacc;
    gacc = gen_i[0];
    pacc = prop_i[0];
    for (int k = 1; k < W; k++) begin
      gacc = gen_i[k] | (prop_i[k] & gacc);
      pacc = pacc & prop_i[k];
    end
    gen_o  = gacc;
    prop_o = pacc;
  end

  always_comb begin
    if (!$isunknown({gen_i, prop_i, cin_i})) begin
      for (int k = 1; k < W; k++) begin
        p_carry_recur_r5: assert (cry_o[k] ==
            (gen_i[k-1] | (prop_i[k-1] & cry_o[k-1])))
          else $error("flat carry disagrees with recurrence at %0d", k);
      end
      p_span_out_r4: assert ((gen_o | (prop_o & cin_i)) ==
          (gen_i[W-1] | (prop_i[W-1] & cry_o[W-1])))
        else $error("span summary disagrees with top carry");
    end
  end
endmodule

// File: rtl/cla_hier_adder.sv
module cla_hier_adder #(
  parameter int unsigned GROUP_W  = cla_pkg::DEF_GROUP_W,
  parameter int unsigned N_GROUPS = cla_pkg::DEF_N_GROUPS
) (
  input  logic [GROUP_W*N_GROUPS-1:0] a_i,
  input  logic [GROUP_W*N_GROUPS-1:0] b_i,
  input  logic                        cin_i,
  output logic [GROUP_W*N_GROUPS-1:0] sum_o,
  output logic                        cout_o,
  output logic                        gen_o,
  output logic                        prop_o
);
  localparam int unsigned WIDTH = GROUP_W * N_GROUPS;

  logic [WIDTH-1:0]    bit_g;
  logic [WIDTH-1:0]    bit_p;
  logic [WIDTH-1:0]    bit_c;
  logic [N_GROUPS-1:0] grp_g;
  logic [N_GROUPS-1:0] grp_p;
  logic [N_GROUPS-1:0] grp_c;

  cla_pg #(.W(WIDTH)) u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .g_o (bit_g),
    .p_o (bit_p)
  );

  for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_grp
    cla_lookahead #(.W(GROUP_W)) u_grp (
      .gen_i  (bit_g[gi*GROUP_W +: GROUP_W]),
      .prop_i (bit_p[gi*GROUP_W +: GROUP_W]),
      .cin_i  (grp_c[gi]),
      .cry_o  (bit_c[gi*GROUP_W +: GROUP_W]),
      .gen_o  (grp_g[gi]),
      .prop_o (grp_p[gi])
    );
  end

  cla_lookahead #(.W(N_GROUPS)) u_top (
    .gen_i  (grp_g),
    .prop_i (grp_p),
    .cin_i  (cin_i),
    .cry_o  (grp_c),
    .gen_o  (gen_o),
    .prop_o (prop_o)
  );

  assign sum_o  = a_i ^ b_i ^ bit_c;
  assign cout_o = gen_o | (prop_o & cin_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_sum_matches_r1: assert ({cout_o, sum_o} ==
          ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
        else $error("sum mismatch");
      p_block_pass_r2: assert (prop_o == &(a_i | b_i))
        else $error("block pass flag wrong");
      p_block_make_r3: assert (gen_o == (({1'b0, a_i} + {1'b0, b_i}) >> WIDTH))
        else $error("block make flag wrong");
      p_top_carry_r4: assert (cout_o ==
          (grp_g[N_GROUPS-1] | (grp_p[N_GROUPS-1] & grp_c[N_GROUPS-1])))
        else $error("carry out disagrees with top slice");
    end
  end
endmodule

// File: tb/cla_hier_adder_tb_top.sv
module cla_hier_adder_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout, gen, prop;
  int           total = 0;
  int           bad = 0;
  bit           done = 0;

  always #5 clk = ~clk;

  cla_hier_adder dut_i (
    .a_i (a), .b_i (b), .cin_i (cin),
    .sum_o (sum), .cout_o (cout), .gen_o (gen), .prop_o (prop)
  );

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(posedge clk);
    #1;
    a = av; b = bv; cin = cv;
    #3;
  endtask

  task automatic check_all(input string req);
    logic [W:0] ref_full;
    logic       ref_g, ref_p;
    ref_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    ref_g    = ((17'(a) + 17'(b)) >> W) != 0;
    ref_p    = &(a | b);
    total++;
    if ({cout, sum} !== ref_full || gen !== ref_g || prop !== ref_p ||
        cout !== (ref_g | (ref_p & cin))) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%b got c=%b s=%h g=%b p=%b exp c=%b s=%h g=%b p=%b",
               req, a, b, cin, cout, sum, gen, prop,
               ref_full[W], ref_full[W-1:0], ref_g, ref_p);
    end
  endtask

  task automatic t_reset_state();
    apply('0, '0, 1'b0);
    check_all("R1 zero state");
  endtask

  task automatic t_boundaries();
    // R5: carries launched below each slice boundary
    apply(16'h000F, 16'h0001, 1'b0); check_all("R5 into slice1");
    apply(16'h00FF, 16'h0001, 1'b0); check_all("R5 into slice2");
    apply(16'h0FFF, 16'h0001, 1'b0); check_all("R5 into slice3");
    apply(16'h0FF8, 16'h0008, 1'b0); check_all("R5 from bit3");
    apply(16'h0F0F, 16'h00F1, 1'b1); check_all("R5 mixed");
  endtask

  task automatic t_full_pass();
    apply(16'hFFFF, 16'h0000, 1'b1);
    check_all("R6 full chain");
    total++;
    if (sum !== 16'h0000 || cout !== 1'b1 || prop !== 1'b1 || gen !== 1'b0) begin
      bad++;
      $display("FAIL R6 got s=%h c=%b p=%b g=%b exp s=0000 c=1 p=1 g=0", sum, cout, prop, gen);
    end
    apply(16'hAAAA, 16'h5555, 1'b0); check_all("R2 pass no carry");
  endtask

  task automatic t_make_flags();
    apply(16'h8000, 16'h8000, 1'b0); check_all("R3 make at top");
    apply(16'h0001, 16'h0001, 1'b0); check_all("R3 make at bottom");
    apply(16'h7FFF, 16'h0001, 1'b1); check_all("R4 carry in only");
    apply(16'hFFFF, 16'hFFFF, 1'b1); check_all("R4 all ones");
  endtask

  task automatic t_history();
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h1234, 16'h4321, 1'b0); check_all("R7 after ones");
    apply(16'h0000, 16'h0000, 1'b0);
    apply(16'h1234, 16'h4321, 1'b0); check_all("R7 after zeros");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 512; i++) begin
      apply({4'(i >> 8), 8'h5A, 4'(i)}, {8'hA5, 4'(i >> 4), 4'(i + 3)}, 1'(i >> 3));
      check_all("R1 low slice sweep");
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check_all("R1 random");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_boundaries();
    t_full_pass();
    t_make_flags();
    t_history();
    t_sweep();
    t_random();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule